// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block decides, once per instruction boundary, which pending interrupt source the processor core services next and which 8-bit type number the entry sequencer must use to fetch its vector. It weighs four levels of request: an internal exception group (divide error, software interrupt with an immediate type, overflow trap, breakpoint), a latched non-maskable request from an edge on its pin, a maskable request gated by the interrupt-enable flag, and a single-step request gated by the trap flag.

Internal exceptions, the non-maskable request and single step resolve straight away: the block raises a one-cycle start strobe with the type in the cycle after the boundary. A maskable request first runs a two-pulse acknowledge handshake on an active-low output; the external controller's type byte is captured at the end of the second pulse, and the start strobe follows. Requests that lose arbitration are not consumed and are weighed again at the next boundary.

Top module: `irq_prio_resolver`

## Requirements
- R1: On a boundary with a valid exception request the start strobe rises in the next cycle with a type chosen by the 2-bit kind code: 0 (divide error) gives type 0, 1 (software interrupt) gives the immediate type byte (any of 0..255), 2 (overflow trap) gives type 4, 3 (breakpoint) gives type 3; this group beats every other source.
- R2: An overflow-trap request (kind 2) while the overflow flag is 0 produces nothing from the exception group; lower-priority sources are then weighed as if no exception were present.
- R3: A rising edge on the non-maskable pin is latched and held until it is serviced with type 2; servicing clears the latch, so the next quiet boundary produces no start.
- R4: The latched non-maskable request beats the maskable request and single step; when it loses to an exception it stays pending and is serviced at a later boundary.
- R5: A maskable request is serviced only while the enable flag is 1 and no higher source is present; with the flag at 0 it causes neither an acknowledge pulse nor a start.
- R6: A maskable service drives the acknowledge output low for PULSE_W cycles, high for GAP_W cycles, then low for PULSE_W cycles; the type input is sampled in the final cycle of the second pulse, and the start strobe with that type follows in the next cycle with the acknowledge output high.
- R7: With the trap flag at 1 and no other source present, a boundary produces a start with type 1.
- R8: No start occurs without a boundary or a finished handshake, and boundaries that arrive while a handshake is in progress are ignored.
- R9: After reset the start strobe is 0, the acknowledge output is high and the non-maskable latch is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| exc_req_i | input | 1 | Internal exception request |
| exc_kind_i | input | 2 | Exception kind: 0 divide, 1 software, 2 overflow trap, 3 breakpoint |
| exc_type_i | input | 8 | Immediate type for a software interrupt |
| ovf_i | input | 1 | Overflow flag |
| nmi_i | input | 1 | Non-maskable request pin (rising edge) |
| intr_i | input | 1 | Maskable request pin |
| if_i | input | 1 | Interrupt-enable flag |
| tf_i | input | 1 | Trap (single-step) flag |
| ext_type_i | input | 8 | Type byte from the external controller |
| inta_n_o | output | 1 | Acknowledge output, active low |
| start_o | output | 1 | One-cycle start strobe for the entry sequencer |
| type_o | output | 8 | Type number, valid with start_o |

## Verification
The hardest situation to reach is a non-maskable edge that is latched but loses to an exception, together with a maskable request and a set trap flag, and then must still be serviced exactly once. The stimulus sweeps every combination of exception presence, kind, overflow flag, pending edge, maskable pin, enable flag and trap flag, arming the latch with a short pin pulse before each boundary, and follows each case with quiet boundaries that must first drain any surviving non-maskable request and then show nothing. During each handshake the boundary is held high and a decoy type byte is driven until the final pulse cycle, so ignored boundaries and a wrong sampling instant both show at the ports.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int TYPE_W = 8;

  typedef enum logic [1:0] {
    EXC_DIV = 2'd0,
    EXC_SWI = 2'd1,
    EXC_OVF = 2'd2,
    EXC_BRK = 2'd3
  } exc_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXC  = 3'd1,
    SRC_NMI  = 3'd2,
    SRC_MASK = 3'd3,
    SRC_STEP = 3'd4
  } src_e;

  localparam logic [TYPE_W-1:0] VEC_DIV  = 8'd0;
  localparam logic [TYPE_W-1:0] VEC_STEP = 8'd1;
  localparam logic [TYPE_W-1:0] VEC_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] VEC_BRK  = 8'd3;
  localparam logic [TYPE_W-1:0] VEC_OVF  = 8'd4;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);

  logic nmi_q, nmi_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    rise   = nmi_i & ~nmi_q;
    nmi_d  = nmi_i;
    // a fresh edge wins over a same-cycle clear
    pend_d = rise | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_prio_pkg::*;
(
  input  logic              exc_req_i,
  input  logic [1:0]        exc_kind_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              ovf_i,
  input  logic              nmi_pend_i,
  input  logic              intr_i,
  input  logic              if_i,
  input  logic              tf_i,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o
);

  logic exc_ok;

  always_comb begin
    exc_ok = exc_req_i && !((exc_kind_i == EXC_OVF) && !ovf_i);
    src_o  = SRC_NONE;
    type_o = '0;
    if (exc_ok) begin
      src_o = SRC_EXC;
      unique case (exc_kind_i)
        EXC_DIV: type_o = VEC_DIV;
        EXC_SWI: type_o = exc_type_i;
        EXC_OVF: type_o = VEC_OVF;
        default: type_o = VEC_BRK;
      endcase
    end else if (nmi_pend_i) begin
      src_o  = SRC_NMI;
      type_o = VEC_NMI;
    end else if (intr_i && if_i) begin
      src_o  = SRC_MASK;
    end else if (tf_i) begin
      src_o  = SRC_STEP;
      type_o = VEC_STEP;
    end
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic inta_n_o,
  output logic busy_o,
  output logic done_o
);

  localparam int MAXW  = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_W - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_W - 1);

  typedef enum logic [1:0] {AK_IDLE, AK_P1, AK_GAP, AK_P2} ack_state_e;

  ack_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    unique case (state_q)
      AK_IDLE: begin
        if (go_i) begin
          state_d = AK_P1;
          cnt_d   = '0;
        end
      end
      AK_P1: begin
        if (cnt_q == PULSE_END) begin
          state_d = AK_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      AK_GAP: begin
        if (cnt_q == GAP_END) begin
          state_d = AK_P2;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        if (cnt_q == PULSE_END) begin
          state_d = AK_IDLE;
          cnt_d   = '0;
          done_o  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign inta_n_o = !((state_q == AK_P1) || (state_q == AK_P2));
  assign busy_o   = (state_q != AK_IDLE);

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int PULSE_W = 2,
  parameter int GAP_W   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic        exc_req_i,
  input  logic [1:0]  exc_kind_i,
  input  logic [7:0]  exc_type_i,
  input  logic        ovf_i,
  input  logic        nmi_i,
  input  logic        intr_i,
  input  logic        if_i,
  input  logic        tf_i,
  input  logic [7:0]  ext_type_i,
  output logic        inta_n_o,
  output logic        start_o,
  output logic [7:0]  type_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  src_e              sel_src;
  logic [TYPE_W-1:0] sel_type;
  logic              nmi_pend;
  logic              ack_busy, ack_done;
  logic              decide, fire_now, ack_go, nmi_clr;

  logic              start_q, start_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic              type_en;

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irq_prio_pick u_pick (
    .exc_req_i  (exc_req_i),
    .exc_kind_i (exc_kind_i),
    .exc_type_i (exc_type_i),
    .ovf_i      (ovf_i),
    .nmi_pend_i (nmi_pend),
    .intr_i     (intr_i),
    .if_i       (if_i),
    .tf_i       (tf_i),
    .src_o      (sel_src),
    .type_o     (sel_type)
  );

  irq_ack_seq #(
    .PULSE_W (PULSE_W),
    .GAP_W   (GAP_W)
  ) u_ack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .go_i     (ack_go),
    .inta_n_o (inta_n_o),
    .busy_o   (ack_busy),
    .done_o   (ack_done)
  );

  always_comb begin
    decide   = boundary_i && !ack_busy;
    fire_now = decide && ((sel_src == SRC_EXC) || (sel_src == SRC_NMI) ||
                          (sel_src == SRC_STEP));
    ack_go   = decide && (sel_src == SRC_MASK);
    nmi_clr  = decide && (sel_src == SRC_NMI);
    start_d  = fire_now | ack_done;
    type_en  = start_d;
    type_d   = ack_done ? ext_type_i : sel_type;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q <= 1'b0;
      type_q  <= '0;
    end else begin
      start_q <= start_d;
      if (type_en) begin
        type_q <= type_d;
      end
    end
  end

  assign start_o = start_q;
  assign type_o  = type_q;

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary_i,
  input logic       exc_req_i,
  input logic [1:0] exc_kind_i,
  input logic       ovf_i,
  input logic       nmi_i,
  input logic       if_i,
  input logic       start_o,
  input logic [7:0] type_o,
  input logic       inta_n_o,
  input logic       busy,
  input logic       nmi_pend
);

  a_r8_start_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> ($past(boundary_i && !busy) || $past(busy)));

  a_r6_no_start_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n_o |-> !start_o);

  a_r5_masked_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !busy && !if_i) |=> inta_n_o);

  a_r1_divide_first: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !busy && exc_req_i && exc_kind_i == 2'd0)
      |=> (start_o && type_o == 8'd0));

  a_r3_nmi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |=> nmi_pend);

  a_r4_nmi_over_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !busy && nmi_pend &&
     !(exc_req_i && !(exc_kind_i == 2'd2 && !ovf_i)))
      |=> (start_o && type_o == 8'd2));

endmodule

bind irq_prio_resolver irq_prio_resolver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .boundary_i (boundary_i),
  .exc_req_i  (exc_req_i),
  .exc_kind_i (exc_kind_i),
  .ovf_i      (ovf_i),
  .nmi_i      (nmi_i),
  .if_i       (if_i),
  .start_o    (start_o),
  .type_o     (type_o),
  .inta_n_o   (inta_n_o),
  .busy       (ack_busy),
  .nmi_pend   (nmi_pend)
);

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;

  localparam int PW = 2;
  localparam int GW = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       boundary_i, exc_req_i, ovf_i, nmi_i, intr_i, if_i, tf_i;
  logic [1:0] exc_kind_i;
  logic [7:0] exc_type_i, ext_type_i;
  logic       inta_n_o, start_o;
  logic [7:0] type_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_resolver #(.PULSE_W(PW), .GAP_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .exc_req_i(exc_req_i), .exc_kind_i(exc_kind_i), .exc_type_i(exc_type_i),
    .ovf_i(ovf_i), .nmi_i(nmi_i), .intr_i(intr_i), .if_i(if_i), .tf_i(tf_i),
    .ext_type_i(ext_type_i), .inta_n_o(inta_n_o), .start_o(start_o),
    .type_o(type_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    boundary_i = 0; exc_req_i = 0; exc_kind_i = 0; exc_type_i = 0;
    ovf_i = 0; nmi_i = 0; intr_i = 0; if_i = 0; tf_i = 0; ext_type_i = 0;
  endtask

  task automatic nmi_pulse();
    nmi_i = 1; step(); nmi_i = 0; step();
  endtask

  // one quiet boundary; expect a start with type t, or none when t < 0
  task automatic quiet_boundary(input string req, input int t);
    boundary_i = 1; step(); boundary_i = 0;
    if (t < 0) begin
      chk(req, start_o, 0);
    end else begin
      chk(req, start_o, 1);
      chk(req, type_o, t);
    end
    step();
  endtask

  task automatic run_case(input int idx);
    bit er, ov, nm, it, ie, tr, exc_ok;
    bit [1:0] kd;
    bit [7:0] imm, ev;
    int exp_t;
    string req;
    er = idx[0]; kd = idx[2:1]; ov = idx[3]; nm = idx[4];
    it = idx[5]; ie = idx[6]; tr = idx[7];
    imm = 8'((idx * 37 + 5) & 255);
    ev  = imm ^ 8'h5A;
    exc_ok = er && !(kd == 2'd2 && !ov);
    if (nm) nmi_pulse();
    exc_req_i = er; exc_kind_i = kd; exc_type_i = imm; ovf_i = ov;
    intr_i = it; if_i = ie; tf_i = tr; ext_type_i = ~ev;
    boundary_i = 1;
    step();
    if (exc_ok) begin
      case (kd)
        2'd0: exp_t = 0;
        2'd1: exp_t = imm;
        2'd2: exp_t = 4;
        default: exp_t = 3;
      endcase
      chk("R1 exc start", start_o, 1);
      chk("R1 exc type", type_o, exp_t);
      boundary_i = 0;
    end else if (nm) begin
      req = er ? "R2 into-no-ovf falls to nmi" : "R4 nmi over lower";
      chk(req, start_o, 1);
      chk("R3 nmi type", type_o, 2);
      boundary_i = 0;
    end else if (it && ie) begin
      // boundary stays high through the handshake: must be ignored (R8)
      for (int j = 0; j < PW; j++) begin
        chk("R6 first pulse low", inta_n_o, 0);
        chk("R8 no start in handshake", start_o, 0);
        step();
      end
      for (int j = 0; j < GW; j++) begin
        chk("R6 gap high", inta_n_o, 1);
        chk("R8 no start in handshake", start_o, 0);
        step();
      end
      for (int j = 0; j < PW; j++) begin
        chk("R6 second pulse low", inta_n_o, 0);
        chk("R8 no start in handshake", start_o, 0);
        if (j == PW - 1) ext_type_i = ev;
        step();
      end
      chk("R5 mask start", start_o, 1);
      chk("R6 captured type", type_o, ev);
      chk("R6 ack released", inta_n_o, 1);
      boundary_i = 0;
    end else if (tr) begin
      chk("R7 step start", start_o, 1);
      chk("R7 step type", type_o, 1);
      boundary_i = 0;
    end else begin
      req = (it && !ie) ? "R5 masked ignored" : "R2 into-no-ovf nothing";
      chk(req, start_o, 0);
      chk(req, inta_n_o, 1);
      boundary_i = 0;
    end
    step();
    quiet();
    if (nm && exc_ok) quiet_boundary("R4 nmi kept pending", 2);
    quiet_boundary(nm ? "R3 latch cleared" : "R8 quiet boundary", -1);
  endtask

  initial begin
    quiet();
    rst_n = 0;
    repeat (4) step();
    chk("R9 reset start", start_o, 0);
    chk("R9 reset ack", inta_n_o, 1);
    rst_n = 1;
    repeat (3) step();
    chk("R9 start after reset", start_o, 0);
    chk("R9 ack after reset", inta_n_o, 1);
    quiet_boundary("R9 latch clear", -1);

    nmi_pulse();
    for (int j = 0; j < 5; j++) begin
      chk("R8 no boundary no start", start_o, 0);
      step();
    end
    quiet_boundary("R3 nmi serviced late", 2);
    quiet_boundary("R3 latch cleared", -1);

    for (int idx = 0; idx < 256; idx++) run_case(idx);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule